// File: doc/BRIEF.md
# Receive Frame Address Filter

The filter sits between a byte-level receive deframer and the receive buffer. It watches a stream of received frames, each opened by a start marker and closed by an end marker, and judges every frame by its first data byte, which carries the frame's destination address. Frames that pass are forwarded byte for byte, one cycle late, with a start pulse on the first forwarded byte and a one-cycle end-of-frame event. Frames that fail vanish: no bytes, no start pulse, no end event. Each judged frame also yields a one-cycle decision strobe with an accept flag.

Three run-time settings steer the judgement: a filter enable, a group-match enable and the station's own 8-bit address. With the filter off every frame passes. With it on, the group-match setting chooses between an exact byte compare (own address or the all-ones broadcast byte) and a compare of only the upper four bits (own address upper nibble or the all-ones nibble). The settings are taken from the port values present in the cycle the first byte arrives.

Top module: `rx_addr_filter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is 0 after that edge and the filter returns to idle, so a data byte after reset is ignored until a start marker arrives.
- R2: When `cfg_filter_en` is 0 at the first byte, the frame is accepted whatever its first byte and whatever `cfg_group_en` is.
- R3: When `cfg_filter_en` is 1 and `cfg_group_en` is 0 at the first byte, the frame is accepted only if the first byte equals `cfg_own_addr` or equals 8'hFF.
- R4: When `cfg_filter_en` is 1 and `cfg_group_en` is 1 at the first byte, the frame is accepted only if bits [7:4] of the first byte equal bits [7:4] of `cfg_own_addr` or equal 4'hF; bits [3:0] of both are ignored.
- R5: The first data byte of a frame is the byte with `in_valid` high in the start-marker cycle or at the first `in_valid` after it. One cycle after that byte, `dec_valid` pulses with `dec_accept` giving the verdict; for an accepted frame `out_valid` and `out_sof` are high in that same cycle with `out_data` equal to the first byte.
- R6: Every later byte of an accepted frame appears on `out_data` with `out_valid` high exactly one cycle after it was presented; a rejected frame produces no `out_valid` or `out_sof` at all.
- R7: `out_eof` pulses for one cycle, one cycle after the end marker, only for an accepted frame; a rejected frame gives no end event. A byte and an end marker in the same cycle are taken byte first.
- R8: A frame whose end marker arrives before any data byte is rejected (a `dec_valid` pulse with `dec_accept` 0, no other output) when the filter is enabled, and accepted (`dec_valid`, `dec_accept`, `out_sof` and `out_eof` together, `out_valid` low) when it is disabled.
- R9: Changes of `cfg_own_addr`, `cfg_filter_en` or `cfg_group_en` after the first byte do not change the verdict or the forwarding of the frame in progress.
- R10: A start marker inside an open frame aborts that frame with no end event and starts address capture afresh; the new frame is judged on its own first byte.
- R11: Data bytes and end markers outside an open frame, or after a rejected frame's end marker, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sof | input | 1 | Start-of-frame marker |
| in_valid | input | 1 | Received data byte present |
| in_data | input | DATA_W | Received data byte |
| in_eof | input | 1 | End-of-frame marker |
| cfg_own_addr | input | DATA_W | Station's own address |
| cfg_filter_en | input | 1 | Enables address filtering |
| cfg_group_en | input | 1 | Selects upper-nibble group matching |
| out_sof | output | 1 | First byte (or empty frame) of an accepted frame |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | DATA_W | Forwarded byte |
| out_eof | output | 1 | End-of-frame event of an accepted frame |
| dec_valid | output | 1 | Per-frame verdict strobe |
| dec_accept | output | 1 | Verdict: 1 accepted, 0 dropped |

## Verification
The bench sweeps all 256 first-byte values under every combination of the two enables for two own addresses, one of which has an all-ones upper nibble, so a filter that compared the wrong nibble, forgot the broadcast value or let the group setting leak into exact mode would accept or drop the wrong frames. Empty frames are sent both ways; a design that waited for a byte would never emit a verdict. A mid-frame start marker is sent after an accepted first byte, and a design that failed to reset capture would forward the new rejected frame or emit a stale end event. Settings are flipped after the first byte, stray bytes and markers are sent between frames, and a byte is sent in the start cycle and with the end marker to pin the order of events within one cycle.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

    typedef enum logic [1:0] {
        FRM_IDLE = 2'd0,
        FRM_ADDR = 2'd1,
        FRM_PASS = 2'd2,
        FRM_DROP = 2'd3
    } frm_state_e;

    typedef struct packed {
        logic sof;
        logic eof;
        logic dec_valid;
        logic dec_accept;
    } beat_flags_t;

endpackage

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
    parameter int DATA_W  = 8,
    parameter int GROUP_W = 4
) (
    input  logic [DATA_W-1:0] addr_byte,
    input  logic [DATA_W-1:0] own_addr,
    input  logic              group_en,
    output logic              hit
);
    localparam int GRP_LSB = DATA_W - GROUP_W;

    logic exact_hit;
    logic group_hit;

    always_comb begin
        exact_hit = (addr_byte == own_addr) || (addr_byte == {DATA_W{1'b1}});
    end

    generate
        if (GROUP_W >= DATA_W) begin : g_grp_full
            always_comb group_hit = exact_hit;
        end else begin : g_grp_part
            logic [GROUP_W-1:0] rx_grp;
            logic [GROUP_W-1:0] own_grp;
            always_comb begin
                rx_grp    = addr_byte[DATA_W-1:GRP_LSB];
                own_grp   = own_addr[DATA_W-1:GRP_LSB];
                group_hit = (rx_grp == own_grp) || (rx_grp == {GROUP_W{1'b1}});
            end
        end
    endgenerate

    always_comb begin
        hit = group_en ? group_hit : exact_hit;
    end

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
    import rx_addr_filter_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sof,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eof,
    input  logic              cfg_filter_en,
    input  logic              addr_hit,
    output beat_flags_t       beat_flags,
    output logic              beat_valid,
    output logic [DATA_W-1:0] beat_data,
    output frm_state_e        state_o
);
    typedef struct packed {
        frm_state_e st;
    } ctrl_reg_t;

    ctrl_reg_t  reg_d;
    ctrl_reg_t  reg_q;
    frm_state_e cur_st;
    logic       keep;

    always_comb begin
        reg_d      = reg_q;
        beat_flags = '0;
        beat_valid = 1'b0;
        beat_data  = '0;
        keep       = 1'b0;

        // a start marker always opens a fresh capture, aborting any open frame
        cur_st = in_sof ? FRM_ADDR : reg_q.st;

        // byte handling comes before the end marker within one cycle
        if (in_valid) begin
            unique case (cur_st)
                FRM_ADDR: begin
                    keep                  = !cfg_filter_en || addr_hit;
                    beat_flags.dec_valid  = 1'b1;
                    beat_flags.dec_accept = keep;
                    if (keep) begin
                        beat_flags.sof = 1'b1;
                        beat_valid     = 1'b1;
                        beat_data      = in_data;
                        cur_st         = FRM_PASS;
                    end else begin
                        cur_st = FRM_DROP;
                    end
                end
                FRM_PASS: begin
                    beat_valid = 1'b1;
                    beat_data  = in_data;
                end
                default: begin
                end
            endcase
        end

        if (in_eof) begin
            unique case (cur_st)
                FRM_ADDR: begin
                    // empty frame: nothing to compare, verdict from the enable alone
                    keep                  = !cfg_filter_en;
                    beat_flags.dec_valid  = 1'b1;
                    beat_flags.dec_accept = keep;
                    beat_flags.sof        = keep;
                    beat_flags.eof        = keep;
                end
                FRM_PASS: begin
                    beat_flags.eof = 1'b1;
                end
                default: begin
                end
            endcase
            cur_st = FRM_IDLE;
        end

        reg_d.st = cur_st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q.st <= FRM_IDLE;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign state_o = reg_q.st;

    // a dropped frame stays dropped until a marker closes or restarts it
    p_drop_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.st == FRM_DROP && !in_sof && !in_eof) |=> (reg_q.st == FRM_DROP));

    // an end marker without a new start always returns the tracker to idle
    p_eof_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_eof && !in_sof) |=> (reg_q.st == FRM_IDLE));

    // a start marker with no byte and no end leaves capture armed
    p_sof_arms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sof && !in_valid && !in_eof) |=> (reg_q.st == FRM_ADDR));

endmodule

// File: rtl/rx_beat_reg.sv
module rx_beat_reg
    import rx_addr_filter_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  beat_flags_t       flags_in,
    input  logic              valid_in,
    input  logic [DATA_W-1:0] data_in,
    output beat_flags_t       flags_out,
    output logic              valid_out,
    output logic [DATA_W-1:0] data_out
);
    typedef struct packed {
        beat_flags_t       flags;
        logic              valid;
        logic [DATA_W-1:0] data;
    } beat_reg_t;

    beat_reg_t beat_d;
    beat_reg_t beat_q;

    always_comb begin
        beat_d.flags = flags_in;
        beat_d.valid = valid_in;
        beat_d.data  = valid_in ? data_in : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign flags_out = beat_q.flags;
    assign valid_out = beat_q.valid;
    assign data_out  = beat_q.data;

    // a start pulse only ever comes with an accepting verdict
    p_sof_has_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_q.flags.sof |-> (beat_q.flags.dec_valid && beat_q.flags.dec_accept));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rx_addr_filter_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int GROUP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sof,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] cfg_own_addr,
    input  logic              cfg_filter_en,
    input  logic              cfg_group_en,
    output logic              out_sof,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eof,
    output logic              dec_valid,
    output logic              dec_accept
);
    logic              addr_hit;
    beat_flags_t       nxt_flags;
    logic              nxt_valid;
    logic [DATA_W-1:0] nxt_data;
    frm_state_e        frm_state;
    beat_flags_t       cur_flags;

    rx_addr_match #(
        .DATA_W (DATA_W),
        .GROUP_W(GROUP_W)
    ) u_match (
        .addr_byte(in_data),
        .own_addr (cfg_own_addr),
        .group_en (cfg_group_en),
        .hit      (addr_hit)
    );

    rx_frame_ctrl #(
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_sof       (in_sof),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_eof       (in_eof),
        .cfg_filter_en(cfg_filter_en),
        .addr_hit     (addr_hit),
        .beat_flags   (nxt_flags),
        .beat_valid   (nxt_valid),
        .beat_data    (nxt_data),
        .state_o      (frm_state)
    );

    rx_beat_reg #(
        .DATA_W(DATA_W)
    ) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags_in (nxt_flags),
        .valid_in (nxt_valid),
        .data_in  (nxt_data),
        .flags_out(cur_flags),
        .valid_out(out_valid),
        .data_out (out_data)
    );

    assign out_sof    = cur_flags.sof;
    assign out_eof    = cur_flags.eof;
    assign dec_valid  = cur_flags.dec_valid;
    assign dec_accept = cur_flags.dec_accept;

    // filter disabled at the first byte: the verdict next cycle must be accept
    p_open_accepts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_filter_en && (in_sof || frm_state == FRM_ADDR))
        |=> (dec_valid && dec_accept));

    // a forwarded byte always traces back to a presented byte one cycle earlier
    p_fwd_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) && out_data == $past(in_data)));

    // an end event always follows an end marker
    p_eof_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> $past(in_eof));

    // a rejecting verdict is silent on every other output
    p_drop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> (!out_valid && !out_sof && !out_eof));

    // nothing is emitted from idle without a start marker
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_state == FRM_IDLE && !in_sof) |=> (!out_valid && !dec_valid && !out_eof));

endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_sof = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_eof = 1'b0;
    logic [W-1:0] cfg_own_addr = 8'h5A;
    logic         cfg_filter_en = 1'b0;
    logic         cfg_group_en = 1'b0;
    logic         out_sof, out_valid, out_eof, dec_valid, dec_accept;
    logic [W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    rx_addr_filter uut (
        .clk(clk), .rst_n(rst_n),
        .in_sof(in_sof), .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof),
        .cfg_own_addr(cfg_own_addr), .cfg_filter_en(cfg_filter_en), .cfg_group_en(cfg_group_en),
        .out_sof(out_sof), .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    always #2.5 clk = ~clk;

    // packed view: {sof, valid, data, eof, dec_valid, dec_accept}
    function automatic logic [12:0] pk(logic s, logic v, logic [7:0] d, logic e, logic dv, logic da);
        return {s, v, d, e, dv, da};
    endfunction

    task automatic chk(string tag, logic [12:0] exp);
        logic [12:0] got;
        got = pk(out_sof, out_valid, out_data, out_eof, dec_valid, dec_accept);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %013b expected %013b (sof,valid,data,eof,dv,da)", tag, got, exp);
        end
    endtask

    // drive one cycle of inputs from a falling edge; returns at the next falling edge
    task automatic step(logic s, logic v, logic [7:0] d, logic e);
        in_sof = s; in_valid = v; in_data = d; in_eof = e;
        @(posedge clk);
        @(negedge clk);
        in_sof = 1'b0; in_valid = 1'b0; in_data = '0; in_eof = 1'b0;
    endtask

    function automatic logic verdict(logic [7:0] b, logic [7:0] own, logic fe, logic ge);
        if (!fe) return 1'b1;
        if (ge) return (b[7:4] == own[7:4]) || (b[7:4] == 4'hF);
        return (b == own) || (b == 8'hFF);
    endfunction

    task automatic send_frame(string tag, logic [7:0] first, int nbytes);
        logic acc;
        acc = verdict(first, cfg_own_addr, cfg_filter_en, cfg_group_en);
        step(1, 0, 0, 0);
        chk({"R5 ", tag, " sof cycle"}, '0);
        step(0, 1, first, 0);
        chk({"R5 ", tag}, pk(acc, acc, acc ? first : 8'h00, 0, 1, acc));
        for (int i = 1; i < nbytes; i++) begin
            logic [7:0] b;
            b = first ^ 8'(i * 37);
            step(0, 1, b, 0);
            chk("R6 body", pk(0, acc, acc ? b : 8'h00, 0, 0, 0));
        end
        step(0, 0, 0, 1);
        chk("R7 end", pk(0, 0, 0, acc, 0, 0));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset
        @(negedge clk);
        step(1, 1, 8'h33, 0);
        chk("R1 in reset", '0);
        step(0, 0, 0, 0);
        chk("R1 reset held", '0);
        rst_n = 1'b1;
        step(0, 1, 8'h44, 0);
        chk("R1 byte after reset ignored", '0);
        step(0, 0, 0, 1);
        chk("R11 stray eof", '0);

        // R2/R3/R4: sweep every first byte, both own addresses, all enable settings
        for (int a = 0; a < 2; a++) begin
            cfg_own_addr = (a == 0) ? 8'h5A : 8'hF3;
            for (int m = 0; m < 4; m++) begin
                cfg_filter_en = m[1];
                cfg_group_en  = m[0];
                for (int b = 0; b < 256; b++) begin
                    send_frame(m[1] ? (m[0] ? "R4" : "R3") : "R2", 8'(b), 2);
                end
            end
        end

        // R8: empty frames
        cfg_own_addr = 8'h5A; cfg_group_en = 1'b0;
        cfg_filter_en = 1'b1;
        step(1, 0, 0, 0);
        step(0, 0, 0, 1);
        chk("R8 empty filtered", pk(0, 0, 0, 0, 1, 0));
        cfg_filter_en = 1'b0;
        step(1, 0, 0, 0);
        step(0, 0, 0, 1);
        chk("R8 empty open", pk(1, 0, 0, 1, 1, 1));

        // R9: settings change after an accepted first byte
        cfg_filter_en = 1'b1; cfg_own_addr = 8'h5A;
        step(1, 0, 0, 0);
        step(0, 1, 8'h5A, 0);
        chk("R9 first", pk(1, 1, 8'h5A, 0, 1, 1));
        cfg_own_addr = 8'h11; cfg_group_en = 1'b1;
        step(0, 1, 8'h99, 0);
        chk("R9 body kept", pk(0, 1, 8'h99, 0, 0, 0));
        step(0, 0, 0, 1);
        chk("R9 end kept", pk(0, 0, 0, 1, 0, 0));
        // and after a rejected first byte
        cfg_own_addr = 8'h5A; cfg_group_en = 1'b0;
        step(1, 0, 0, 0);
        step(0, 1, 8'h12, 0);
        chk("R9 reject", pk(0, 0, 0, 0, 1, 0));
        cfg_filter_en = 1'b0;
        step(0, 1, 8'h77, 0);
        chk("R9 still dropped", '0);
        step(0, 0, 0, 1);
        chk("R9 no end", '0);

        // R11: stray traffic after a rejected frame's end
        step(0, 1, 8'h5A, 0);
        chk("R11 stray byte", '0);

        // R10: abort an accepted frame with a new start, new frame rejected
        cfg_filter_en = 1'b1;
        step(1, 0, 0, 0);
        step(0, 1, 8'hFF, 0);
        chk("R10 first accepted", pk(1, 1, 8'hFF, 0, 1, 1));
        step(0, 1, 8'h21, 0);
        chk("R10 body", pk(0, 1, 8'h21, 0, 0, 0));
        step(1, 0, 0, 0);
        chk("R10 abort silent", '0);
        step(0, 1, 8'h5B, 0);
        chk("R10 new frame judged", pk(0, 0, 0, 0, 1, 0));
        step(0, 1, 8'h22, 0);
        chk("R10 new frame dropped", '0);
        step(0, 0, 0, 1);
        chk("R10 no end", '0);
        // abort a rejected frame, new frame accepted; start and first byte in one cycle
        step(1, 0, 0, 0);
        step(0, 1, 8'h01, 0);
        chk("R10 reject", pk(0, 0, 0, 0, 1, 0));
        step(1, 1, 8'h5A, 0);
        chk("R5 byte in start cycle", pk(1, 1, 8'h5A, 0, 1, 1));
        step(0, 1, 8'hC3, 1);
        chk("R7 byte with end", pk(0, 1, 8'hC3, 1, 0, 0));
        step(0, 1, 8'h5A, 0);
        chk("R11 byte after end", '0);

        // R1: reset mid-frame returns to idle
        step(1, 1, 8'h5A, 0);
        rst_n = 1'b0;
        step(0, 1, 8'h66, 0);
        chk("R1 reset mid-frame", '0);
        rst_n = 1'b1;
        step(0, 1, 8'h67, 0);
        chk("R1 idle after reset", '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule